// File: doc/BRIEF.md
# Word-Mapped Serial Port

This block is an asynchronous serial transceiver that sits on a 16-bit peripheral bus as four word registers: status, data, a data-high storage word and a baud divider. Software writes a byte to the data register to send it. The byte waits in a one-entry holding register until the transmit shift register is free, and is then sent as a ten-bit frame. Received frames are shifted in from the line and moved into the receive side of the data register. A five-bit status word reports the state of both directions.

The divider sets a tick that runs at sixteen times the bit rate. The transmitter uses this tick to time each bit. The receiver uses it to find the start edge, to confirm the start bit at its middle, and to sample each later bit at its centre. Bus reads are combinational on the address. A read strobe on the data register marks the received byte as consumed.

Top module: `sio_word_port`

## Requirements
- R1: The transmit line is high when idle. A frame is one low start bit, eight data bits with the least significant bit first, and one high stop bit. Each bit lasts 16*(DIV+1) clock cycles, where DIV is the divider value.
- R2: The word addresses are 0 status, 1 data, 2 data-high and 3 divider. After reset every register reads as zero. Status uses bits 4:0, the data register uses bits 7:0, and data-high uses bits 15:8. All other read bits are zero.
- R3: A write to address 1 while transmit-full (status bit 1) is clear loads the byte into the holding register and sets transmit-full. A write to address 1 while transmit-full is set is ignored.
- R4: If the shift register is idle and transmit-full is set, the held byte moves into the shift register at the next clock edge. That edge clears transmit-full and sets transmitter-running (status bit 0). Transmitter-running stays set until the stop bit ends.
- R5: When a received frame completes, its byte appears at address 1, bits 7:0, and receive-full (status bit 2) is set. A read strobe on address 1 clears receive-full, but a frame completing on the same edge takes priority.
- R6: Receiver overrun (status bit 3) is written on every completed frame. It becomes 1 if receive-full was still set at that moment and 0 otherwise. Between frames it holds its value.
- R7: Framing error (status bit 4) is written on every completed frame. It becomes 1 if that frame's stop-bit sample was low and 0 otherwise.
- R8: A start bit is accepted only on a high-to-low transition of the receive line, and only if the line is still low half a bit later. A low pulse shorter than half a bit produces no byte and leaves the status unchanged.
- R9: The divider at address 3 sets the baud tick period to DIV+1 clock cycles. Transmit and receive both use this tick.
- R10: Data-high at address 2 stores bits 15:8 of a write and returns them on a read. It has no effect on the serial line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 2 | Word address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; consumes received data at address 1 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data selected by bus_addr |
| line_rx | input | 1 | Serial receive line |
| line_tx | output | 1 | Serial transmit line |

## Verification
The hardest case to reach from the ports is a framing error that is followed at once by a normal frame. After a low stop bit the line is still low, so a receiver that only looks for a low level could start a false frame. The stimulus drives a frame whose stop bit is held low for the full bit time and then releases the line. It then sends a correct frame and checks that the framing flag returns to 0 and that no extra byte was received. Overrun is reached by sending two frames with no read strobe between them, followed by a third frame after a read, which shows that the flag is cleared again. The transmit side is compared with a behavioural model on every clock, including a write made while the holding register is full.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam int BUS_W   = 16;
    localparam int ADDR_W  = 2;
    localparam int BYTE_W  = 8;
    localparam int STAT_W  = 5;

    typedef enum logic [ADDR_W-1:0] {
        REG_STAT = 2'd0,
        REG_DATA = 2'd1,
        REG_DHI  = 2'd2,
        REG_DIV  = 2'd3
    } sio_reg_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    // field order fixes the bit positions: frame_err is bit 4, tx_busy is bit 0
    typedef struct packed {
        logic frame_err;
        logic rx_ovr;
        logic rx_full;
        logic tx_full;
        logic tx_busy;
    } sio_status_t;

    function automatic logic [BUS_W-1:0] sio_status_word(input sio_status_t s);
        return {{(BUS_W-STAT_W){1'b0}}, s};
    endfunction

    function automatic logic [BUS_W-1:0] sio_low_byte(input logic [BYTE_W-1:0] b);
        return {{(BUS_W-BYTE_W){1'b0}}, b};
    endfunction

    function automatic logic [BUS_W-1:0] sio_high_byte(input logic [BYTE_W-1:0] b);
        return {b, {(BUS_W-BYTE_W){1'b0}}};
    endfunction

endpackage

// File: rtl/sio_baud.sv
module sio_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_q;

    // ">=" keeps the period short when the divider is lowered mid-count
    assign tick_o = (cnt_q >= div_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    AST_TICK_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> (cnt_q == '0)); // R9

endmodule

// File: rtl/sio_tx.sv
module sio_tx #(
    parameter int OSR    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              full_o,
    output logic              busy_o,
    output logic              line_o
);

    localparam int FRAME_W = DATA_W + 2;
    localparam int OSR_W   = $clog2(OSR);
    localparam int BIT_W   = $clog2(FRAME_W);

    logic [DATA_W-1:0]  hold_q;
    logic               full_q;
    logic               busy_q;
    logic [FRAME_W-1:0] shreg_q;
    logic [OSR_W-1:0]   ph_q;
    logic [BIT_W-1:0]   bitn_q;

    logic last_slice;
    assign last_slice = (ph_q == OSR_W'(OSR - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            full_q  <= 1'b0;
            busy_q  <= 1'b0;
            shreg_q <= '1;
            ph_q    <= '0;
            bitn_q  <= '0;
        end else begin
            if (!busy_q && full_q) begin
                busy_q  <= 1'b1;
                full_q  <= 1'b0;
                shreg_q <= {1'b1, hold_q, 1'b0};
                ph_q    <= '0;
                bitn_q  <= '0;
            end else if (busy_q && tick_i) begin
                if (last_slice) begin
                    ph_q    <= '0;
                    shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
                    if (bitn_q == BIT_W'(FRAME_W - 1)) begin
                        busy_q <= 1'b0;
                    end else begin
                        bitn_q <= bitn_q + BIT_W'(1);
                    end
                end else begin
                    ph_q <= ph_q + OSR_W'(1);
                end
            end
            if (wr_i && !full_q) begin
                hold_q <= wdata_i;
                full_q <= 1'b1;
            end
        end
    end

    assign full_o = full_q;
    assign busy_o = busy_q;
    assign line_o = busy_q ? shreg_q[0] : 1'b1;

    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> !line_o); // R1
    AST_LOAD_EMPTIES_HOLD: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> $fell(full_q)); // R4
    AST_FULL_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (full_q && wr_i) |=> $stable(hold_q)); // R3

endmodule

// File: rtl/sio_rx.sv
module sio_rx
    import sio_pkg::*;
#(
    parameter int OSR    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              line_i,
    input  logic              rd_ack_i,
    output logic [DATA_W-1:0] data_o,
    output logic              full_o,
    output logic              ovr_o,
    output logic              ferr_o
);

    localparam int OSR_W = $clog2(OSR);
    localparam int HALF  = OSR / 2;
    localparam int CNT_W = $clog2(DATA_W + 1);

    logic [1:0]        sync_q;
    logic              line_s;
    logic              prev_q;
    rx_state_e         state_q;
    logic [OSR_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  bitn_q;
    logic [DATA_W-1:0] shreg_q;
    logic [DATA_W-1:0] data_q;
    logic              full_q;
    logic              ovr_q;
    logic              ferr_q;
    logic              xfer;
    logic              slice_end;

    assign line_s    = sync_q[1];
    assign slice_end = (cnt_q == OSR_W'(OSR - 1));
    assign xfer      = (state_q == RX_STOP) && tick_i && slice_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b11;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], line_i};
            if (tick_i) begin
                prev_q <= line_s;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            bitn_q  <= '0;
            shreg_q <= '0;
        end else if (tick_i) begin
            unique case (state_q)
                RX_IDLE: begin
                    if (prev_q && !line_s) begin
                        state_q <= RX_START;
                        cnt_q   <= '0;
                    end
                end
                RX_START: begin
                    if (cnt_q == OSR_W'(HALF - 1)) begin
                        cnt_q   <= '0;
                        bitn_q  <= '0;
                        state_q <= line_s ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt_q <= cnt_q + OSR_W'(1);
                    end
                end
                RX_DATA: begin
                    if (slice_end) begin
                        cnt_q   <= '0;
                        shreg_q <= {line_s, shreg_q[DATA_W-1:1]};
                        if (bitn_q == CNT_W'(DATA_W - 1)) begin
                            state_q <= RX_STOP;
                        end else begin
                            bitn_q <= bitn_q + CNT_W'(1);
                        end
                    end else begin
                        cnt_q <= cnt_q + OSR_W'(1);
                    end
                end
                RX_STOP: begin
                    if (slice_end) begin
                        cnt_q   <= '0;
                        state_q <= RX_IDLE;
                    end else begin
                        cnt_q <= cnt_q + OSR_W'(1);
                    end
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
            ferr_q <= 1'b0;
        end else if (xfer) begin
            data_q <= shreg_q;
            full_q <= 1'b1;
            ovr_q  <= full_q;
            ferr_q <= !line_s;
        end else if (rd_ack_i) begin
            full_q <= 1'b0;
        end
    end

    assign data_o = data_q;
    assign full_o = full_q;
    assign ovr_o  = ovr_q;
    assign ferr_o = ferr_q;

    AST_XFER_SETS_FULL: assert property (@(posedge clk) disable iff (rst)
        xfer |=> full_q); // R5
    AST_READ_CLEARS_FULL: assert property (@(posedge clk) disable iff (rst)
        (rd_ack_i && !xfer) |=> !full_q); // R5
    AST_OVR_HOLDS_BETWEEN: assert property (@(posedge clk) disable iff (rst)
        !xfer |=> $stable(ovr_q)); // R6
    AST_FERR_HOLDS_BETWEEN: assert property (@(posedge clk) disable iff (rst)
        !xfer |=> $stable(ferr_q)); // R7
    AST_START_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
        (state_q == RX_IDLE && !prev_q) |=> (state_q == RX_IDLE)); // R8

endmodule

// File: rtl/sio_word_port.sv
module sio_word_port
    import sio_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int OSR   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              line_rx,
    output logic              line_tx
);

    logic [DIV_W-1:0]  div_q;
    logic [BYTE_W-1:0] dhi_q;
    logic              tick;
    logic              tx_wr;
    logic              rx_ack;
    logic [BYTE_W-1:0] rx_data;
    sio_status_t       stat;
    sio_reg_e          sel;

    assign sel    = sio_reg_e'(bus_addr);
    assign tx_wr  = bus_wr && (sel == REG_DATA);
    assign rx_ack = bus_rd && (sel == REG_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            dhi_q <= '0;
        end else if (bus_wr) begin
            if (sel == REG_DIV) begin
                div_q <= bus_wdata[DIV_W-1:0];
            end
            if (sel == REG_DHI) begin
                dhi_q <= bus_wdata[BUS_W-1:BUS_W-BYTE_W];
            end
        end
    end

    sio_baud #(.DIV_W(DIV_W)) u_baud (
        .clk    (clk),
        .rst    (rst),
        .div_i  (div_q),
        .tick_o (tick)
    );

    sio_tx #(.OSR(OSR), .DATA_W(BYTE_W)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick),
        .wr_i    (tx_wr),
        .wdata_i (bus_wdata[BYTE_W-1:0]),
        .full_o  (stat.tx_full),
        .busy_o  (stat.tx_busy),
        .line_o  (line_tx)
    );

    sio_rx #(.OSR(OSR), .DATA_W(BYTE_W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick),
        .line_i   (line_rx),
        .rd_ack_i (rx_ack),
        .data_o   (rx_data),
        .full_o   (stat.rx_full),
        .ovr_o    (stat.rx_ovr),
        .ferr_o   (stat.frame_err)
    );

    always_comb begin
        unique case (sel)
            REG_STAT: bus_rdata = sio_status_word(stat);
            REG_DATA: bus_rdata = sio_low_byte(rx_data);
            REG_DHI:  bus_rdata = sio_high_byte(dhi_q);
            REG_DIV:  bus_rdata = BUS_W'(div_q);
            default:  bus_rdata = '0;
        endcase
    end

    AST_TX_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (!stat.tx_busy && !$past(stat.tx_busy)) |-> line_tx); // R1
    AST_DHI_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == REG_DHI) |=> (dhi_q == $past(bus_wdata[BUS_W-1:BUS_W-BYTE_W]))); // R10

endmodule

// File: tb/tb_sio_word_port.sv
`timescale 1ns/1ps
module tb_sio_word_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        line_rx = 1'b1;
    logic        line_tx;

    always #2.5 clk = ~clk;

    sio_word_port dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .line_rx   (line_rx),
        .line_tx   (line_tx)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model of the transmit side and the plain registers
    int         m_div, m_bc, m_phase;
    bit         m_full, m_busy;
    logic [7:0] m_hold, m_shift, m_dhi;

    always @(posedge clk) begin
        bit t, old_full, old_busy;
        if (rst) begin
            m_div = 0; m_bc = 0; m_phase = 0;
            m_full = 0; m_busy = 0; m_hold = 0; m_shift = 0; m_dhi = 0;
        end else begin
            t = (m_bc >= m_div);
            old_full = m_full;
            old_busy = m_busy;
            if (old_busy) begin
                if (t) begin
                    m_phase++;
                    if (m_phase == 160) m_busy = 0;
                end
            end else if (old_full) begin
                m_busy = 1; m_full = 0; m_phase = 0; m_shift = m_hold;
            end
            if (bus_wr && bus_addr == 2'd1 && !old_full) begin
                m_hold = bus_wdata[7:0];
                m_full = 1;
            end
            if (bus_wr && bus_addr == 2'd3) m_div = int'(bus_wdata);
            if (bus_wr && bus_addr == 2'd2) m_dhi = bus_wdata[15:8];
            m_bc = t ? 0 : m_bc + 1;
        end
    end

    function automatic logic exp_line();
        logic [9:0] fr;
        if (!m_busy) return 1'b1;
        fr = {1'b1, m_shift, 1'b0};
        return fr[m_phase / 16];
    endfunction

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(line_tx === exp_line(), "R1 line level", {15'h0, line_tx}, {15'h0, exp_line()});
            if (bus_addr == 2'd0)
                check(bus_rdata[1:0] === {m_full, m_busy}, "R3/R4 tx flags",
                      {14'h0, bus_rdata[1:0]}, {14'h0, m_full, m_busy});
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_addr = 2'd0;
    endtask

    task automatic bus_read(input logic [1:0] a, input bit strobe, output logic [15:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_rd = strobe;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0; bus_addr = 2'd0;
    endtask

    task automatic drive_bit(input logic v, input int n);
        #1 line_rx = v;
        repeat (n) @(posedge clk);
    endtask

    task automatic send_rx(input logic [7:0] b, input logic stop, input int n);
        @(posedge clk);
        drive_bit(1'b0, n);
        for (int i = 0; i < 8; i++) drive_bit(b[i], n);
        drive_bit(stop, n);
        drive_bit(1'b1, 3 * n);
    endtask

    task automatic wait_tx_idle();
        while (m_busy || m_full) @(posedge clk);
        repeat (4) @(posedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 16'h0, 16'h1);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] r;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;

        // R2: reset values
        for (int a = 0; a < 4; a++) begin
            bus_read(2'(a), 1'b0, r);
            check(r == 16'h0, "R2 reset value", r, 16'h0);
        end
        check(line_tx == 1'b1, "R1 idle high", {15'h0, line_tx}, 16'h1);

        // R10: data-high storage, R2 lane placement
        bus_write(2'd2, 16'hAB5A);
        bus_read(2'd2, 1'b0, r);
        check(r == 16'hAB00, "R10 data-high readback", r, 16'hAB00);
        bus_write(2'd3, 16'h0005);
        bus_read(2'd3, 1'b0, r);
        check(r == 16'h0005, "R2 divider readback", r, 16'h0005);
        bus_write(2'd3, 16'h0000);

        // R3/R4: transmit with holding register
        bus_write(2'd1, 16'h00A5);
        repeat (3) @(posedge clk);
        bus_write(2'd1, 16'h003C);
        bus_read(2'd0, 1'b0, r);
        check(r[1:0] == 2'b11, "R3 full while running", r, 16'h0003);
        bus_write(2'd1, 16'h00FF);
        wait_tx_idle();
        bus_read(2'd0, 1'b0, r);
        check(r == 16'h0, "R4 flags clear after frames", r, 16'h0);

        // R5: basic receive
        send_rx(8'h3C, 1'b1, 16);
        bus_read(2'd0, 1'b0, r);
        check(r[4:2] == 3'b001, "R5 rx full set", r, 16'h0004);
        bus_read(2'd1, 1'b1, r);
        check(r == 16'h003C, "R5 rx byte", r, 16'h003C);
        bus_read(2'd0, 1'b0, r);
        check(r[2] == 1'b0, "R5 read clears full", r, 16'h0);

        // R6: overrun set then cleared
        send_rx(8'h11, 1'b1, 16);
        send_rx(8'h22, 1'b1, 16);
        bus_read(2'd0, 1'b0, r);
        check(r[4:2] == 3'b011, "R6 overrun set", r, 16'h000C);
        bus_read(2'd1, 1'b1, r);
        check(r == 16'h0022, "R6 newest byte kept", r, 16'h0022);
        send_rx(8'h33, 1'b1, 16);
        bus_read(2'd0, 1'b0, r);
        check(r[4:2] == 3'b001, "R6 overrun cleared", r, 16'h0004);
        bus_read(2'd1, 1'b1, r);

        // R7: framing error then recovery
        send_rx(8'h55, 1'b0, 16);
        bus_read(2'd0, 1'b0, r);
        check(r[4:2] == 3'b101, "R7 framing set", r, 16'h0014);
        bus_read(2'd1, 1'b1, r);
        check(r == 16'h0055, "R7 byte with bad stop", r, 16'h0055);
        send_rx(8'h66, 1'b1, 16);
        bus_read(2'd0, 1'b0, r);
        check(r[4:2] == 3'b001, "R7 framing cleared, no extra byte", r, 16'h0004);
        bus_read(2'd1, 1'b1, r);
        check(r == 16'h0066, "R7 following byte", r, 16'h0066);

        // R8: short glitch is not a start bit
        @(posedge clk);
        drive_bit(1'b0, 4);
        drive_bit(1'b1, 64);
        bus_read(2'd0, 1'b0, r);
        check(r == 16'h0, "R8 glitch ignored", r, 16'h0);
        bus_read(2'd1, 1'b0, r);
        check(r == 16'h0066, "R8 data unchanged", r, 16'h0066);

        // R9: divider of 2, both directions
        bus_write(2'd3, 16'h0002);
        bus_write(2'd1, 16'h0096);
        send_rx(8'hC3, 1'b1, 48);
        wait_tx_idle();
        bus_read(2'd0, 1'b0, r);
        check(r[4:2] == 3'b001, "R9 rx at slow rate", r, 16'h0004);
        bus_read(2'd1, 1'b1, r);
        check(r == 16'h00C3, "R9 rx byte at slow rate", r, 16'h00C3);
        bus_read(2'd2, 1'b0, r);
        check(r == {m_dhi, 8'h00}, "R10 data-high unchanged", r, {m_dhi, 8'h00});

        repeat (10) @(posedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule